// File: doc/BRIEF.md
# Programmable RGB-to-YCbCr Color Matrix

This block takes one 10-bit-per-channel RGB pixel per clock and produces one limited-range YCbCr pixel per clock. Each input channel first gets its own signed offset. The three offset channels are then multiplied by a 3x3 signed fixed-point matrix, in which 1024 stands for 1.0. The sum of each matrix row is rounded and scaled back to integer units. A per-channel post-offset is added, and the result is clipped to the 10-bit range. Using the post-offsets 64, 512 and 512 gives limited-range Y, Cb and Cr for 10-bit video.

Software writes the coefficients, offsets and the enable bit through a simple register-write port. These writes land in a shadow copy. They reach the datapath only on a frame-start strobe, so a frame never sees a mix of old and new settings. A small commit state machine tracks this. It starts in ST_SYNCED, where the active and shadow copies agree. A write moves it to ST_STAGED, where the shadow copy holds changes that are not yet active. A frame-start strobe copies the shadow to the active set and returns it to ST_SYNCED. That copy includes a write made in the same cycle as the strobe. When the enable bit is clear, pixels pass through unchanged with the same latency as converted pixels.

Pixels move under valid/ready handshaking through a fixed three-stage pipeline. The stages are the pre-offset add, the matrix multiply-accumulate with rounding, and the post-offset add with saturation. All three stages stall together while the output is held.

Top module: `csc_matrix`

## Requirements
- R1: After reset, out_valid is low, in_ready is high, and every coefficient, offset and the enable bit are zero, so the first pixels pass through unchanged.
- R2: While the active enable bit (control register, word address 10, bit 0) is 0, out_pix equals in_pix bit for bit. Pixels are packed R/Y in [29:20], G/Cb in [19:10] and B/Cr in [9:0].
- R3: The register map is fixed.
  - Word 0 holds pre-offset 0 in bits 27:16 and pre-offset 1 in bits 11:0. Word 1 holds pre-offset 2 in bits 11:0.
  - Words 2 to 5 each hold two coefficients, the first in bits 28:16 and the second in bits 12:0, in the order 00/01, 02/10, 11/12, 20/21. Word 6 holds coefficient 22 in bits 28:16.
  - Word 8 holds post-offsets 0 and 1, laid out like word 0. Word 9 holds post-offset 2 in bits 11:0.
  - Offsets are 12-bit and coefficients are 13-bit two's-complement values.
- R4: With the enable bit set, output channel r equals (sum over j of c[r][j]*(in_j + pre_j) + 512) shifted arithmetically right by 10, plus post_r.
- R5: Each output channel saturates to 0 when its result is negative and to 1023 when its result exceeds 1023.
- R6: Register writes have no effect on the output until a frame-start strobe. After the strobe, pixels accepted later use the new settings.
- R7: A pixel accepted on a clock edge appears at the output, with out_valid high, after the third following edge when out_ready stays high. It is not visible after the second edge.
- R8: While out_valid is high and out_ready is low, out_pix and out_valid hold and in_ready is low. When out_ready is released, the held pixels leave in their input order.
- R9: Word 7 stores a 2-bit mode field in bits 31:30 and a 3-bit shift field in bits 18:16. Writing any value there leaves the output of the conversion unchanged.
- R10: A register write in the same cycle as the frame-start strobe is part of that commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| frame_start | input | 1 | Commit strobe: shadow settings become active |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block accepts an input pixel this cycle |
| in_pix | input | 30 | Input RGB pixel |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts the output pixel |
| out_pix | output | 30 | Output YCbCr pixel (or the unchanged input in pass-through) |

## Verification
Two situations are the hardest to reach from the ports.

The first is a full pipeline under backpressure. The stimulus drops out_ready and then pushes three pixels on back-to-back edges, so every stage is occupied when the first pixel reaches the output. Only then does the bench release out_ready and watch the three pixels drain in order.

The second is the commit boundary. The stimulus stages a new matrix and shows that it has no effect until the strobe. It then raises a control write and the frame-start strobe in the very same cycle, which checks that the write is part of that commit.

Rounding is reached with coefficients just above and below one half. A residue of -1 must round toward minus one, and only the post-offset lifts that result back into range.

// File: rtl/csc_pkg.sv
package csc_pkg;
    localparam int PIX_W   = 10;
    localparam int NCH     = 3;
    localparam int COEF_W  = 13;
    localparam int OFS_W   = 12;
    localparam int FRAC_W  = 10;
    localparam int ADDR_W  = 4;
    localparam int DATA_W  = 32;
    localparam int BUS_W   = PIX_W * NCH;
    localparam int NCOEF   = NCH * NCH;
    localparam int XMODE_W = 2;
    localparam int XSHF_W  = 3;

    localparam logic [ADDR_W-1:0] A_PRE01  = 4'd0;
    localparam logic [ADDR_W-1:0] A_PRE2   = 4'd1;
    localparam logic [ADDR_W-1:0] A_C0001  = 4'd2;
    localparam logic [ADDR_W-1:0] A_C0210  = 4'd3;
    localparam logic [ADDR_W-1:0] A_C1112  = 4'd4;
    localparam logic [ADDR_W-1:0] A_C2021  = 4'd5;
    localparam logic [ADDR_W-1:0] A_C22    = 4'd6;
    localparam logic [ADDR_W-1:0] A_XMODE  = 4'd7;
    localparam logic [ADDR_W-1:0] A_POST01 = 4'd8;
    localparam logic [ADDR_W-1:0] A_POST2  = 4'd9;
    localparam logic [ADDR_W-1:0] A_CTRL   = 4'd10;

    typedef struct packed {
        logic [NCOEF-1:0][COEF_W-1:0] coef;
        logic [NCH-1:0][OFS_W-1:0]    pre;
        logic [NCH-1:0][OFS_W-1:0]    post;
        logic                         en;
        logic [XMODE_W-1:0]           xmode;
        logic [XSHF_W-1:0]            xshift;
    } csc_cfg_t;

    typedef enum logic {
        ST_SYNCED,
        ST_STAGED
    } commit_st_t;
endpackage

// File: rtl/csc_regs.sv
module csc_regs
    import csc_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_wr,
    input  logic [ADDR_W-1:0]             reg_addr,
    input  logic [DATA_W-1:0]             reg_wdata,
    input  logic                          frame_start,
    output logic [NCOEF-1:0][COEF_W-1:0]  coef,
    output logic [NCH-1:0][OFS_W-1:0]     pre,
    output logic [NCH-1:0][OFS_W-1:0]     post,
    output logic                          en
);
    localparam int HI = 16;

    csc_cfg_t   shadow_q, shadow_d, active_q;
    commit_st_t state_q, state_d;
    logic       load_active;
    logic       unused_wbits;

    assign unused_wbits = ^{reg_wdata[29], reg_wdata[15:13]};

    // shadow update from the write port
    always_comb begin
        shadow_d = shadow_q;
        if (reg_wr) begin
            case (reg_addr)
                A_PRE01:  begin
                    shadow_d.pre[0] = reg_wdata[HI +: OFS_W];
                    shadow_d.pre[1] = reg_wdata[0 +: OFS_W];
                end
                A_PRE2:   shadow_d.pre[2] = reg_wdata[0 +: OFS_W];
                A_C0001:  begin
                    shadow_d.coef[0] = reg_wdata[HI +: COEF_W];
                    shadow_d.coef[1] = reg_wdata[0 +: COEF_W];
                end
                A_C0210:  begin
                    shadow_d.coef[2] = reg_wdata[HI +: COEF_W];
                    shadow_d.coef[3] = reg_wdata[0 +: COEF_W];
                end
                A_C1112:  begin
                    shadow_d.coef[4] = reg_wdata[HI +: COEF_W];
                    shadow_d.coef[5] = reg_wdata[0 +: COEF_W];
                end
                A_C2021:  begin
                    shadow_d.coef[6] = reg_wdata[HI +: COEF_W];
                    shadow_d.coef[7] = reg_wdata[0 +: COEF_W];
                end
                A_C22:    shadow_d.coef[8] = reg_wdata[HI +: COEF_W];
                A_XMODE:  begin
                    shadow_d.xmode  = reg_wdata[31:30];
                    shadow_d.xshift = reg_wdata[18:16];
                end
                A_POST01: begin
                    shadow_d.post[0] = reg_wdata[HI +: OFS_W];
                    shadow_d.post[1] = reg_wdata[0 +: OFS_W];
                end
                A_POST2:  shadow_d.post[2] = reg_wdata[0 +: OFS_W];
                A_CTRL:   shadow_d.en = reg_wdata[0];
                default:  ;
            endcase
        end
    end

    // commit state machine: next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SYNCED: if (reg_wr && !frame_start) state_d = ST_STAGED;
            ST_STAGED: if (frame_start)            state_d = ST_SYNCED;
        endcase
    end

    // commit state machine: outputs
    always_comb begin
        load_active = 1'b0;
        unique case (state_q)
            ST_SYNCED: load_active = frame_start && reg_wr;
            ST_STAGED: load_active = frame_start;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_SYNCED;
            shadow_q <= '0;
            active_q <= '0;
        end else begin
            state_q  <= state_d;
            shadow_q <= shadow_d;
            if (load_active) active_q <= shadow_d;
        end
    end

    assign coef = active_q.coef;
    assign pre  = active_q.pre;
    assign post = active_q.post;
    assign en   = active_q.en;

    // R6: in the synced state the live settings match the staged copy
    assert_synced_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SYNCED) |-> (active_q == shadow_q));

    // R6: without a strobe, the live settings never move
    assert_no_commit_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(active_q));
endmodule

// File: rtl/csc_datapath.sv
module csc_datapath
    import csc_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    output logic                          in_ready,
    input  logic [BUS_W-1:0]              in_pix,
    output logic                          out_valid,
    input  logic                          out_ready,
    output logic [BUS_W-1:0]              out_pix,
    input  logic [NCOEF-1:0][COEF_W-1:0]  coef,
    input  logic [NCH-1:0][OFS_W-1:0]     pre,
    input  logic [NCH-1:0][OFS_W-1:0]     post,
    input  logic                          en
);
    localparam int X_W    = OFS_W + 2;
    localparam int PROD_W = X_W + COEF_W;
    localparam int SUM_W  = PROD_W + $clog2(NCH);
    localparam int Y_W    = SUM_W - FRAC_W;
    localparam int Z_W    = Y_W + 1;
    localparam logic signed [SUM_W-1:0] ROUND_C   = SUM_W'(1 << (FRAC_W - 1));
    localparam logic signed [Z_W-1:0]   PIX_MAX_Z = Z_W'((1 << PIX_W) - 1);

    logic adv;

    logic                 s1_valid, s1_byp;
    logic [BUS_W-1:0]     s1_raw;
    logic signed [X_W-1:0] s1_x [NCH];
    logic signed [X_W-1:0] x_d  [NCH];

    logic                 s2_valid, s2_byp;
    logic [BUS_W-1:0]     s2_raw;
    logic signed [Y_W-1:0] s2_y [NCH];
    logic signed [Y_W-1:0] y_d  [NCH];

    logic [BUS_W-1:0]     out_d;

    assign adv      = !out_valid || out_ready;
    assign in_ready = adv;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        // stage 1: pre-offset
        assign x_d[g] = X_W'($signed({1'b0, in_pix[(NCH-1-g)*PIX_W +: PIX_W]}))
                      + X_W'($signed(pre[g]));

        // stage 2: row multiply-accumulate, round, scale
        logic signed [SUM_W-1:0]  acc;
        logic signed [PROD_W-1:0] prod;
        always_comb begin
            acc  = ROUND_C;
            prod = '0;
            for (int j = 0; j < NCH; j++) begin
                prod = PROD_W'($signed(coef[g*NCH+j])) * PROD_W'(s1_x[j]);
                acc  = acc + SUM_W'(prod);
            end
        end
        assign y_d[g] = Y_W'(acc >>> FRAC_W);

        // stage 3: post-offset and saturation
        logic signed [Z_W-1:0] z;
        assign z = Z_W'(s2_y[g]) + Z_W'($signed(post[g]));
        always_comb begin
            if (z[Z_W-1])
                out_d[(NCH-1-g)*PIX_W +: PIX_W] = '0;
            else if (z > PIX_MAX_Z)
                out_d[(NCH-1-g)*PIX_W +: PIX_W] = '1;
            else
                out_d[(NCH-1-g)*PIX_W +: PIX_W] = z[PIX_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            s2_valid  <= 1'b0;
            out_valid <= 1'b0;
            s1_byp    <= 1'b1;
            s2_byp    <= 1'b1;
            s1_raw    <= '0;
            s2_raw    <= '0;
            out_pix   <= '0;
            for (int c = 0; c < NCH; c++) begin
                s1_x[c] <= '0;
                s2_y[c] <= '0;
            end
        end else if (adv) begin
            s1_valid  <= in_valid;
            s1_byp    <= !en;
            s1_raw    <= in_pix;
            s2_valid  <= s1_valid;
            s2_byp    <= s1_byp;
            s2_raw    <= s1_raw;
            out_valid <= s2_valid;
            out_pix   <= s2_byp ? s2_raw : out_d;
            for (int c = 0; c < NCH; c++) begin
                s1_x[c] <= x_d[c];
                s2_y[c] <= y_d[c];
            end
        end
    end

    // R8: a held output keeps its value until taken
    assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_pix)));

    // R8: the first stage is frozen while input is refused
    assert_stage_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> $stable(s1_valid));

    // R7: output valid only rises behind a valid second stage
    assert_valid_chain_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(s2_valid));
endmodule

// File: rtl/csc_matrix.sv
module csc_matrix
    import csc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              frame_start,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BUS_W-1:0]  in_pix,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BUS_W-1:0]  out_pix
);
    logic [NCOEF-1:0][COEF_W-1:0] coef;
    logic [NCH-1:0][OFS_W-1:0]    pre;
    logic [NCH-1:0][OFS_W-1:0]    post;
    logic                         en;

    csc_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .frame_start (frame_start),
        .coef        (coef),
        .pre         (pre),
        .post        (post),
        .en          (en)
    );

    csc_datapath u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_pix    (in_pix),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_pix   (out_pix),
        .coef      (coef),
        .pre       (pre),
        .post      (post),
        .en        (en)
    );
endmodule

// File: tb/csc_matrix_test.sv
`timescale 1ns/1ps
module csc_matrix_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        frame_start = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [29:0] in_pix = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [29:0] out_pix;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    int pend_coef [9];
    int pend_pre [3];
    int pend_post [3];
    bit pend_en;
    int act_coef [9];
    int act_pre [3];
    int act_post [3];
    bit act_en;

    always #2 clk = ~clk;

    csc_matrix uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .frame_start(frame_start),
        .in_valid(in_valid), .in_ready(in_ready), .in_pix(in_pix),
        .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [29:0] model(input logic [29:0] p);
        logic [29:0] r;
        if (!act_en) return p;
        r = '0;
        for (int row = 0; row < 3; row++) begin
            longint s = 0;
            for (int j = 0; j < 3; j++)
                s += longint'(act_coef[row*3+j]) * (longint'(p[(2-j)*10 +: 10]) + act_pre[j]);
            s = (s + 512) >>> 10;
            s += act_post[row];
            if (s < 0) s = 0;
            if (s > 1023) s = 1023;
            r[(2-row)*10 +: 10] = 10'(s);
        end
        return r;
    endfunction

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    function automatic logic [31:0] pk_c(input int hi, input int lo);
        return {3'b0, 13'(hi), 3'b0, 13'(lo)};
    endfunction

    function automatic logic [31:0] pk_o(input int hi, input int lo);
        return {4'b0, 12'(hi), 4'b0, 12'(lo)};
    endfunction

    task automatic write_all();
        wr(4'd0, pk_o(pend_pre[0], pend_pre[1]));
        wr(4'd1, pk_o(0, pend_pre[2]));
        wr(4'd2, pk_c(pend_coef[0], pend_coef[1]));
        wr(4'd3, pk_c(pend_coef[2], pend_coef[3]));
        wr(4'd4, pk_c(pend_coef[4], pend_coef[5]));
        wr(4'd5, pk_c(pend_coef[6], pend_coef[7]));
        wr(4'd6, pk_c(pend_coef[8], 0));
        wr(4'd8, pk_o(pend_post[0], pend_post[1]));
        wr(4'd9, pk_o(0, pend_post[2]));
        wr(4'd10, {31'b0, pend_en});
    endtask

    task automatic commit();
        @(negedge clk);
        frame_start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        frame_start = 1'b0;
        act_coef = pend_coef; act_pre = pend_pre; act_post = pend_post; act_en = pend_en;
    endtask

    task automatic set_diag(input int d0, input int d1, input int d2);
        pend_coef = '{default: 0};
        pend_coef[0] = d0; pend_coef[4] = d1; pend_coef[8] = d2;
    endtask

    task automatic send_check(input logic [29:0] p, input string tag);
        logic [29:0] e;
        e = model(p);
        @(negedge clk);
        in_valid = 1'b1; in_pix = p;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(!out_valid, "R7 early valid", 32'(out_valid), 32'd0);
        @(posedge clk);
        @(negedge clk);
        check(out_valid, {tag, " valid"}, 32'(out_valid), 32'd1);
        check(out_pix == e, tag, 32'(out_pix), 32'(e));
    endtask

    function automatic logic [29:0] px(input int r, input int g, input int b);
        return {10'(r), 10'(g), 10'(b)};
    endfunction

    task automatic t_reset();
        @(negedge clk);
        check(!out_valid, "R1 out_valid after reset", 32'(out_valid), 32'd0);
        check(in_ready, "R1 in_ready after reset", 32'(in_ready), 32'd1);
        send_check(px(5, 600, 1023), "R1 reset pass-through");
    endtask

    task automatic t_bypass();
        send_check(px(0, 0, 0), "R2 bypass zero");
        send_check(px(1023, 512, 1), "R2 bypass mixed");
        check(model(px(1023, 512, 1)) == px(1023, 512, 1), "R2 model", 32'(model(px(1023, 512, 1))), 32'(px(1023, 512, 1)));
    endtask

    task automatic t_staged();
        set_diag(1024, 1024, 1024);
        pend_pre = '{100, -50, 7}; pend_post = '{0, 0, 0}; pend_en = 1'b1;
        write_all();
        send_check(px(300, 300, 300), "R6 staged not yet live");
        commit();
        send_check(px(300, 300, 300), "R6 live after strobe");
        send_check(px(1000, 20, 0), "R3 identity with pre-offsets");
    endtask

    task automatic t_709();
        pend_coef = '{186, 627, 63, -103, -345, 448, 448, -407, -41};
        pend_pre = '{0, 0, 0}; pend_post = '{64, 512, 512}; pend_en = 1'b1;
        write_all();
        commit();
        check(model(px(0, 0, 0)) == px(64, 512, 512), "R4 black model", 32'(model(px(0, 0, 0))), 32'(px(64, 512, 512)));
        send_check(px(0, 0, 0), "R4 black");
        send_check(px(1023, 1023, 1023), "R4 white");
        send_check(px(1023, 0, 0), "R4 red");
        send_check(px(100, 700, 300), "R3 mixed");
    endtask

    task automatic t_sat();
        set_diag(1024, 1024, 1024);
        pend_pre = '{0, 0, 0}; pend_post = '{512, 512, 512}; pend_en = 1'b1;
        write_all();
        commit();
        send_check(px(1000, 600, 511), "R5 high clip");
        set_diag(-1024, -1024, -1024);
        pend_post = '{0, 0, 0};
        write_all();
        commit();
        send_check(px(1, 500, 1023), "R5 low clip");
    endtask

    task automatic t_round();
        set_diag(512, 511, -513);
        pend_pre = '{0, 0, 0}; pend_post = '{0, 0, 5}; pend_en = 1'b1;
        write_all();
        commit();
        check(model(px(1, 1, 1)) == px(1, 0, 4), "R4 round model", 32'(model(px(1, 1, 1))), 32'(px(1, 0, 4)));
        send_check(px(1, 1, 1), "R4 rounding");
    endtask

    task automatic t_xmode();
        wr(4'd7, 32'hFFFF_FFFF);
        commit();
        send_check(px(1, 1, 1), "R9 mode/shift ignored");
        send_check(px(800, 3, 90), "R9 mode/shift ignored 2");
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'd10; reg_wdata = 32'd0; frame_start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0; frame_start = 1'b0;
        pend_en = 1'b0;
        act_coef = pend_coef; act_pre = pend_pre; act_post = pend_post; act_en = pend_en;
        send_check(px(77, 888, 3), "R10 same-cycle write committed");
    endtask

    task automatic t_backpressure();
        logic [29:0] e0, e1, e2;
        set_diag(1024, 1024, 1024);
        pend_pre = '{1, 2, 3}; pend_post = '{0, 0, 0}; pend_en = 1'b1;
        write_all();
        commit();
        e0 = model(px(10, 20, 30));
        e1 = model(px(40, 50, 60));
        e2 = model(px(70, 80, 90));
        @(negedge clk);
        out_ready = 1'b0;
        in_valid = 1'b1; in_pix = px(10, 20, 30);
        @(posedge clk);
        @(negedge clk);
        in_pix = px(40, 50, 60);
        @(posedge clk);
        @(negedge clk);
        in_pix = px(70, 80, 90);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        for (int k = 0; k < 3; k++) begin
            check(out_valid && out_pix == e0, "R8 held pixel", 32'(out_pix), 32'(e0));
            check(!in_ready, "R8 in_ready low", 32'(in_ready), 32'd0);
            @(posedge clk);
            @(negedge clk);
        end
        out_ready = 1'b1;
        check(out_valid && out_pix == e0, "R8 first out", 32'(out_pix), 32'(e0));
        @(posedge clk);
        @(negedge clk);
        check(out_valid && out_pix == e1, "R8 second out", 32'(out_pix), 32'(e1));
        @(posedge clk);
        @(negedge clk);
        check(out_valid && out_pix == e2, "R8 third out", 32'(out_pix), 32'(e2));
        @(posedge clk);
        @(negedge clk);
        check(!out_valid, "R7 drained", 32'(out_valid), 32'd0);
    endtask

    initial begin
        pend_coef = '{default: 0}; pend_pre = '{0, 0, 0}; pend_post = '{0, 0, 0}; pend_en = 1'b0;
        act_coef = pend_coef; act_pre = pend_pre; act_post = pend_post; act_en = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_bypass();
        t_staged();
        t_709();
        t_sat();
        t_round();
        t_xmode();
        t_same_cycle();
        t_backpressure();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule